// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the architectural integer registers of a 32-bit processor core whose register set is banked by operating mode. Sixteen architectural indices are visible at any moment. Which physical register an index reaches depends on a 5-bit mode input. User and system mode see one common set. The fast-interrupt mode swaps in private copies of indices 8 through 14. The supervisor, abort, interrupt and undefined modes swap in private copies of only the stack pointer (index 13) and the link register (index 14). Index 15, the program counter, is one physical register that every mode shares. In total there are 31 physical registers.

Two combinational read ports and one synchronous write port all use architectural indices under the current mode. A second write port serves exception entry. It carries its own mode input and always targets index 14 of that mode's bank. This lets the return address be stored in the same cycle that the core switches mode. When the program counter is written, its low bits are cleared: two bits in 32-bit instruction state and one bit in 16-bit instruction state.

Top module: `mode_banked_rf`

## Requirements
- R1: Every physical register is zero after reset, so every index reads zero under every mode.
- R2: Modes 10000 (user) and 11111 (system) share one set of sixteen registers. Any mode value that is not one of the seven listed encodings uses that same set.
- R3: Under mode 10001 (fast interrupt), indices 8 to 14 reach private registers. Indices 0 to 7 reach the shared registers.
- R4: Under modes 10011, 10111, 10010 and 11011, each mode has its own private registers for indices 13 and 14 only. Indices 0 to 12 reach the shared registers, or the user copies for 8 to 12.
- R5: Index 15 reaches the same physical register under every mode.
- R6: A write takes effect at the rising clock edge. A read of the written index in the same cycle returns the previous value.
- R7: A write to index 15 clears bits [1:0] of the stored value when half_state is 0 and clears only bit 0 when half_state is 1. Index 15 therefore never reads back with bit 0 set.
- R8: The exception port writes index 14 of the bank selected by exc_mode, whatever the current mode is. With exc_mode user or system, this is the shared index 14.
- R9: When both write ports hit the same physical register in one cycle, the exception port's data is stored. When they hit different registers, both writes are stored.
- R10: The two read ports return the contents of their own indices independently in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 5 | Current processor mode, selects the bank for both reads and the normal write |
| half_state | input | 1 | 1 = 16-bit instruction state, 0 = 32-bit state (program counter alignment) |
| rd_a_idx | input | 4 | Read port A architectural index |
| rd_a_data | output | DATA_W | Read port A data |
| rd_b_idx | input | 4 | Read port B architectural index |
| rd_b_data | output | DATA_W | Read port B data |
| wr_en | input | 1 | Normal write enable |
| wr_idx | input | 4 | Normal write architectural index |
| wr_data | input | DATA_W | Normal write data |
| exc_wr_en | input | 1 | Exception-entry link write enable |
| exc_mode | input | 5 | Mode whose index 14 the exception port writes |
| exc_wr_data | input | DATA_W | Return address to store |

## Verification
The bench builds the block with its default DATA_W of 32. This lets the 32-bit patterns, and the all-ones program counter write, exercise the full word and both alignment masks. A vector table writes under one mode and reads under another, which covers shared, fast-interrupt and privileged bank sharing. Directed tests then cover:
- the read-before-write timing;
- the exception port writing a bank other than the current one;
- both write ports colliding on one register.

// File: rtl/brf_pkg.sv
package brf_pkg;

    localparam int ARCH_N    = 16;
    localparam int ARCH_W    = $clog2(ARCH_N);
    localparam int PC_IDX    = ARCH_N - 1;
    localparam int LINK_IDX  = PC_IDX - 1;
    localparam int SP_IDX    = PC_IDX - 2;
    localparam int FIQ_LO    = 8;
    localparam int FIQ_CNT   = PC_IDX - FIQ_LO;
    localparam int PRIV_BANKS = 4;
    localparam int PRIV_CNT  = PC_IDX - SP_IDX;
    localparam int FIQ_BASE  = ARCH_N;
    localparam int PRIV_BASE = FIQ_BASE + FIQ_CNT;
    localparam int PHYS_N    = PRIV_BASE + PRIV_BANKS * PRIV_CNT;
    localparam int PHYS_W    = $clog2(PHYS_N);
    localparam int MODE_W    = 5;

    typedef logic [MODE_W-1:0] mode_t;

    localparam mode_t MODE_USR = 5'b10000;
    localparam mode_t MODE_FIQ = 5'b10001;
    localparam mode_t MODE_IRQ = 5'b10010;
    localparam mode_t MODE_SVC = 5'b10011;
    localparam mode_t MODE_ABT = 5'b10111;
    localparam mode_t MODE_UND = 5'b11011;
    localparam mode_t MODE_SYS = 5'b11111;

    // Privileged banks are contiguous after BANK_FIQ; their order fixes the physical layout.
    typedef enum logic [2:0] {
        BANK_USR,
        BANK_FIQ,
        BANK_SVC,
        BANK_ABT,
        BANK_IRQ,
        BANK_UND
    } bank_e;

    function automatic logic [PHYS_W-1:0] phys_of(bank_e b, logic [ARCH_W-1:0] a);
        int p;
        p = int'(a);
        if (b == BANK_FIQ && p >= FIQ_LO && p < PC_IDX) begin
            p = FIQ_BASE + p - FIQ_LO;
        end else if (b != BANK_USR && b != BANK_FIQ && p >= SP_IDX && p < PC_IDX) begin
            p = PRIV_BASE + PRIV_CNT * (int'(b) - int'(BANK_SVC)) + p - SP_IDX;
        end
        return PHYS_W'(p);
    endfunction

endpackage

// File: rtl/brf_mode_decode.sv
module brf_mode_decode
    import brf_pkg::*;
(
    input  mode_t mode,
    output bank_e bank
);

    always_comb begin
        unique case (mode)
            MODE_FIQ: bank = BANK_FIQ;
            MODE_IRQ: bank = BANK_IRQ;
            MODE_SVC: bank = BANK_SVC;
            MODE_ABT: bank = BANK_ABT;
            MODE_UND: bank = BANK_UND;
            default:  bank = BANK_USR;
        endcase
    end

    always_comb begin
        if (mode == MODE_SYS) begin
            AST_SYS_IS_USER: assert (bank == BANK_USR); // R2
        end
    end

endmodule

// File: rtl/brf_index_map.sv
module brf_index_map
    import brf_pkg::*;
(
    input  bank_e              bank,
    input  logic [ARCH_W-1:0]  arch_idx,
    output logic [PHYS_W-1:0]  phys_idx
);

    always_comb begin
        phys_idx = phys_of(bank, arch_idx);
    end

    always_comb begin
        if (int'(arch_idx) < FIQ_LO) begin
            AST_LOW_SHARED: assert (int'(phys_idx) == int'(arch_idx)); // R3
        end
        if (int'(arch_idx) == PC_IDX) begin
            AST_PC_COMMON: assert (int'(phys_idx) == PC_IDX); // R5
        end
        AST_PHYS_RANGE: assert (int'(phys_idx) < PHYS_N); // R4
    end

endmodule

// File: rtl/brf_storage.sv
module brf_storage
    import brf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int RD_N   = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [RD_N-1:0][PHYS_W-1:0]   rd_phys,
    output logic [RD_N-1:0][DATA_W-1:0]   rd_data,
    input  logic                          wr_en,
    input  logic [PHYS_W-1:0]             wr_phys,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic                          ex_en,
    input  logic [PHYS_W-1:0]             ex_phys,
    input  logic [DATA_W-1:0]             ex_data
);

    typedef struct packed {
        logic [PHYS_N-1:0][DATA_W-1:0] regs;
    } rf_state_t;

    rf_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && int'(wr_phys) < PHYS_N) begin
            st_d.regs[wr_phys] = wr_data;
        end
        // Applied last: the exception port wins a collision.
        if (ex_en && int'(ex_phys) < PHYS_N) begin
            st_d.regs[ex_phys] = ex_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar r = 0; r < RD_N; r++) begin : g_rd
        assign rd_data[r] = st_q.regs[rd_phys[r]];
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !(ex_en && ex_phys == wr_phys)) |=>
        st_q.regs[$past(wr_phys)] == $past(wr_data)); // R6

    AST_EXC_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ex_en |=> st_q.regs[$past(ex_phys)] == $past(ex_data)); // R9

    for (genvar k = 0; k < PHYS_N; k++) begin : g_hold
        AST_UNTOUCHED_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
            (!(wr_en && int'(wr_phys) == k) && !(ex_en && int'(ex_phys) == k)) |=>
            $stable(st_q.regs[k])); // R6
    end

endmodule

// File: rtl/mode_banked_rf.sv
module mode_banked_rf
    import brf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        mode,
    input  logic              half_state,
    input  logic [3:0]        rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [3:0]        rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              exc_wr_en,
    input  logic [4:0]        exc_mode,
    input  logic [DATA_W-1:0] exc_wr_data
);

    localparam int MAP_N   = 4;
    localparam int RD_N    = 2;
    localparam int MAP_WR  = 2;
    localparam int MAP_EXC = 3;

    bank_e                        cur_bank;
    bank_e                        exc_bank;
    bank_e       [MAP_N-1:0]      map_bank;
    logic        [MAP_N-1:0][ARCH_W-1:0] map_arch;
    logic        [MAP_N-1:0][PHYS_W-1:0] map_phys;
    logic        [RD_N-1:0][DATA_W-1:0]  rd_data;
    logic        [DATA_W-1:0]     wr_data_aligned;

    brf_mode_decode u_cur_dec (.mode(mode),     .bank(cur_bank));
    brf_mode_decode u_exc_dec (.mode(exc_mode), .bank(exc_bank));

    assign map_arch[0]       = rd_a_idx;
    assign map_arch[1]       = rd_b_idx;
    assign map_arch[MAP_WR]  = wr_idx;
    assign map_arch[MAP_EXC] = ARCH_W'(LINK_IDX);

    for (genvar m = 0; m < MAP_N; m++) begin : g_map
        if (m == MAP_EXC) begin : g_exc
            assign map_bank[m] = exc_bank;
        end else begin : g_cur
            assign map_bank[m] = cur_bank;
        end
        brf_index_map u_map (
            .bank     (map_bank[m]),
            .arch_idx (map_arch[m]),
            .phys_idx (map_phys[m])
        );
    end

    always_comb begin
        wr_data_aligned = wr_data;
        if (int'(wr_idx) == PC_IDX) begin
            wr_data_aligned[0] = 1'b0;
            if (!half_state) begin
                wr_data_aligned[1] = 1'b0;
            end
        end
    end

    brf_storage #(
        .DATA_W (DATA_W),
        .RD_N   (RD_N)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_phys (map_phys[RD_N-1:0]),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .wr_phys (map_phys[MAP_WR]),
        .wr_data (wr_data_aligned),
        .ex_en   (exc_wr_en),
        .ex_phys (map_phys[MAP_EXC]),
        .ex_data (exc_wr_data)
    );

    assign rd_a_data = rd_data[0];
    assign rd_b_data = rd_data[1];

    always_comb begin
        if (rst_n && int'(rd_a_idx) == PC_IDX) begin
            AST_PC_BIT0_CLEAR: assert (rd_a_data[0] == 1'b0); // R7
        end
    end

    AST_PC_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(wr_idx) == PC_IDX && !half_state) |=>
        (int'(rd_b_idx) != PC_IDX || rd_b_data[1:0] == 2'b00 || $past(exc_wr_en) || wr_en)); // R7

    AST_RESET_ZERO: assert property (@(posedge clk)
        !rst_n |-> (rd_a_data == '0 && rd_b_data == '0)); // R1

endmodule

// File: tb/test_mode_banked_rf.sv
module test_mode_banked_rf;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;
    localparam int NVEC       = 13;

    localparam logic [4:0] M_USR = 5'b10000;
    localparam logic [4:0] M_FIQ = 5'b10001;
    localparam logic [4:0] M_IRQ = 5'b10010;
    localparam logic [4:0] M_SVC = 5'b10011;
    localparam logic [4:0] M_ABT = 5'b10111;
    localparam logic [4:0] M_UND = 5'b11011;
    localparam logic [4:0] M_SYS = 5'b11111;

    typedef struct packed {
        logic [4:0]  wmode;
        logic        wen;
        logic [3:0]  widx;
        logic [31:0] wdata;
        logic [4:0]  rmode;
        logic [3:0]  ridx;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{M_USR, 1'b1, 4'd8,  32'hA0000008, M_USR, 4'd8,  32'hA0000008, 4'd2},  // R2
        '{M_FIQ, 1'b1, 4'd8,  32'hF0000008, M_FIQ, 4'd8,  32'hF0000008, 4'd3},  // R3
        '{M_FIQ, 1'b0, 4'd0,  32'h0,        M_USR, 4'd8,  32'hA0000008, 4'd3},  // R3
        '{M_SYS, 1'b1, 4'd3,  32'h33333333, M_USR, 4'd3,  32'h33333333, 4'd2},  // R2
        '{M_FIQ, 1'b0, 4'd0,  32'h0,        M_FIQ, 4'd3,  32'h33333333, 4'd3},  // R3
        '{M_SVC, 1'b1, 4'd13, 32'h5C000013, M_SVC, 4'd13, 32'h5C000013, 4'd4},  // R4
        '{M_IRQ, 1'b1, 4'd13, 32'h1A000013, M_SVC, 4'd13, 32'h5C000013, 4'd4},  // R4
        '{M_IRQ, 1'b0, 4'd0,  32'h0,        M_IRQ, 4'd13, 32'h1A000013, 4'd4},  // R4
        '{M_ABT, 1'b1, 4'd12, 32'hABC0000C, M_USR, 4'd12, 32'hABC0000C, 4'd4},  // R4
        '{M_UND, 1'b1, 4'd14, 32'h0D000014, M_ABT, 4'd14, 32'h00000000, 4'd4},  // R4
        '{M_USR, 1'b1, 4'd15, 32'h12345678, M_FIQ, 4'd15, 32'h12345678, 4'd5},  // R5
        '{5'b00000, 1'b1, 4'd13, 32'h77770013, M_USR, 4'd13, 32'h77770013, 4'd2}, // R2
        '{M_FIQ, 1'b1, 4'd14, 32'hF0000014, M_UND, 4'd14, 32'h0D000014, 4'd4}   // R4
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  mode = M_USR;
    logic        half_state = 1'b0;
    logic [3:0]  rd_a_idx = '0;
    logic [31:0] rd_a_data;
    logic [3:0]  rd_b_idx = '0;
    logic [31:0] rd_b_data;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        exc_wr_en = 1'b0;
    logic [4:0]  exc_mode = M_USR;
    logic [31:0] exc_wr_data = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mode_banked_rf #(.DATA_W(32)) i_mode_banked_rf (
        .clk, .rst_n, .mode, .half_state,
        .rd_a_idx, .rd_a_data, .rd_b_idx, .rd_b_data,
        .wr_en, .wr_idx, .wr_data,
        .exc_wr_en, .exc_mode, .exc_wr_data
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic read_a(input logic [4:0] m, input logic [3:0] idx, output logic [31:0] d);
        mode = m;
        rd_a_idx = idx;
        #1;
        d = rd_a_data;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        exc_wr_en = 1'b0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [4:0] all_modes [7];
        all_modes = '{M_USR, M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND, M_SYS};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: everything reads zero under every mode
        for (int m = 0; m < 7; m++) begin
            for (int i = 0; i < 16; i++) begin
                mode = all_modes[m];
                rd_a_idx = 4'(i);
                rd_b_idx = 4'(15 - i);
                #1;
                check("R1", rd_a_data, 32'h0);
                check("R1", rd_b_data, 32'h0);
            end
        end

        // R6: same-cycle read sees old value; new value after the edge
        mode = M_USR; rd_a_idx = 4'd5;
        wr_en = 1'b1; wr_idx = 4'd5; wr_data = 32'h00000055;
        #1;
        check("R6", rd_a_data, 32'h0);
        step();
        read_a(M_USR, 4'd5, d);
        check("R6", d, 32'h00000055);

        // Vector table: write under one mode, read under another
        for (int v = 0; v < NVEC; v++) begin
            mode = VECS[v].wmode;
            wr_en = VECS[v].wen;
            wr_idx = VECS[v].widx;
            wr_data = VECS[v].wdata;
            half_state = 1'b0;
            step();
            read_a(VECS[v].rmode, VECS[v].ridx, d);
            check($sformatf("R%0d vec%0d", VECS[v].req, v), d, VECS[v].exp);
        end

        // R10: two read ports at once under fast-interrupt mode
        mode = M_FIQ; rd_a_idx = 4'd3; rd_b_idx = 4'd8;
        #1;
        check("R10 port a", rd_a_data, 32'h33333333);
        check("R10 port b", rd_b_data, 32'hF0000008);

        // R7: program counter alignment in both instruction states
        mode = M_USR; wr_en = 1'b1; wr_idx = 4'd15; wr_data = 32'hFFFFFFFF; half_state = 1'b0;
        step();
        rd_b_idx = 4'd15; #1;
        check("R7 word", rd_b_data, 32'hFFFFFFFC);
        wr_en = 1'b1; wr_idx = 4'd15; wr_data = 32'hFFFFFFFF; half_state = 1'b1;
        step();
        half_state = 1'b0;
        read_a(M_SVC, 4'd15, d);
        check("R7 half", d, 32'hFFFFFFFE);

        // R8: exception port targets its own mode's link register
        mode = M_USR; exc_wr_en = 1'b1; exc_mode = M_IRQ; exc_wr_data = 32'h1E000014;
        step();
        read_a(M_IRQ, 4'd14, d);
        check("R8 irq link", d, 32'h1E000014);
        read_a(M_USR, 4'd14, d);
        check("R8 user link untouched", d, 32'h0);
        mode = M_FIQ; exc_wr_en = 1'b1; exc_mode = M_SYS; exc_wr_data = 32'h5F000014;
        step();
        read_a(M_USR, 4'd14, d);
        check("R8 shared link", d, 32'h5F000014);
        read_a(M_FIQ, 4'd14, d);
        check("R8 fiq link untouched", d, 32'hF0000014);

        // R9: collision, exception port wins
        mode = M_SVC; wr_en = 1'b1; wr_idx = 4'd14; wr_data = 32'h11111111;
        exc_wr_en = 1'b1; exc_mode = M_SVC; exc_wr_data = 32'h22222222;
        step();
        read_a(M_SVC, 4'd14, d);
        check("R9 collision", d, 32'h22222222);

        // R9: different targets, both stored
        mode = M_USR; wr_en = 1'b1; wr_idx = 4'd14; wr_data = 32'h00000033;
        exc_wr_en = 1'b1; exc_mode = M_FIQ; exc_wr_data = 32'h00000044;
        step();
        read_a(M_USR, 4'd14, d);
        check("R9 normal side", d, 32'h00000033);
        read_a(M_FIQ, 4'd14, d);
        check("R9 exception side", d, 32'h00000044);

        // R1: reset again clears banked state
        rst_n = 1'b0;
        #1;
        read_a(M_FIQ, 4'd8, d);
        check("R1 re-reset", d, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule